// File: doc/BRIEF.md
# Trigger-Aligned Peak Finder

This block serves one digitized detector channel. Every clock cycle it takes one 10-bit ADC sample and feeds it into a fixed delay line. A level-1 trigger arrives a fixed time after the physics it refers to: 3.2 µs at a 20 MHz sample clock, which is 64 cycles. The delay line makes the samples at the delay-line tap line up with that trigger. When a trigger is accepted, the block scans the next 50 delayed samples (a 2.5 µs window). It then reports the largest value and its position in the window, together with a one-cycle strobe.

The sample input has no back-pressure. One sample is taken on every clock edge, so its ready is permanently high and it carries no valid. The result side is a valid-only strobe with no ready. A downstream store that cannot take a result raises the buffer-full flag instead. While that flag is high, triggers are refused and any result that completes is dropped. A trigger-reset pulse aborts any search in progress and clears the result registers. The delay line keeps sampling through a trigger-reset.

Top module: `trig_peak_finder`

## Requirements
- R1: The sample at window index 0 is the one presented on the clock edge 64 cycles before the edge on which the trigger is sampled high. Index j is the sample presented 64 − j edges before that trigger edge.
- R2: The reported value is the maximum of the 50 window samples. The reported index (0..49) is the position of that maximum in the window.
- R3: The valid strobe is high for exactly one cycle. It rises after the 50th clock edge counted from the trigger edge, with the trigger edge counted as the first.
- R4: When several window samples share the maximum value, the lowest index is reported.
- R5: Samples just before index 0 or just after index 49 do not affect the result, even when they are larger.
- R6: A trigger sampled while a search window is open is ignored. It produces no extra result and does not restart the window.
- R7: A trigger-reset pulse aborts the open search, so no result follows from it. It also clears the value and index outputs to 0 on the next edge.
- R8: A trigger sampled while buffer-full is high starts no search. A search that completes while buffer-full is high gives no strobe and leaves the outputs unchanged.
- R9: After reset, valid, value and index are all 0.
- R10: The value and index outputs hold their last result until the next result or a trigger-reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | 10 | ADC sample, taken on every rising edge |
| trig | input | 1 | Level-1 trigger pulse |
| trig_rst | input | 1 | Trigger-reset: aborts the search and clears the result |
| buf_full | input | 1 | Downstream store full; blocks new results |
| peak_val | output | 10 | Maximum sample found in the window |
| peak_idx | output | 6 | Window index of that maximum |
| peak_valid | output | 1 | One-cycle result strobe |

## Verification
The hardest cases to reach are the ones where the window sits against a larger sample just outside it, and the ones where a tie or a control pulse lands at a chosen point inside an open window. The bench therefore picks each trigger edge ahead of time. It writes a sample table for the cycles that will later reach the delay-line tap, placing equal maxima, edge maxima and out-of-window spikes at computed positions before those samples are driven. Retriggers, trigger-resets and buffer-full are then timed as offsets from that same trigger edge.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
  localparam int unsigned CLK_MHZ     = 20;
  localparam int unsigned LATENCY_NS  = 3200;
  localparam int unsigned WINDOW_NS   = 2500;
  localparam int unsigned ADC_W       = 10;
  localparam int unsigned DELAY_CYC   = LATENCY_NS * CLK_MHZ / 1000;
  localparam int unsigned WINDOW_CYC  = WINDOW_NS * CLK_MHZ / 1000;
  localparam int unsigned IDX_W       = $clog2(WINDOW_CYC);
endpackage

// File: rtl/tpf_delay_line.sv
module tpf_delay_line #(
  parameter int unsigned W     = 10,
  parameter int unsigned DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= '0;
      else        stage[g] <= stage[g-1];
    end
  end

  assign tap = stage[DEPTH-1];
endmodule

// File: rtl/tpf_peak_tracker.sv
module tpf_peak_tracker #(
  parameter int unsigned W      = 10,
  parameter int unsigned WINDOW = 50,
  localparam int unsigned IW    = $clog2(WINDOW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          start_req,
  input  logic          block,
  input  logic [W-1:0]  sample,
  output logic          done,
  output logic [W-1:0]  res_val,
  output logic [IW-1:0] res_idx
);
  logic          busy;
  logic [IW-1:0] cnt;
  logic [W-1:0]  best_val;
  logic [IW-1:0] best_idx;

  logic          start, take, upd, last;
  logic [IW-1:0] cur_idx;

  assign start   = !busy && start_req && !block;
  assign take    = start || busy;
  assign cur_idx = start ? '0 : cnt;
  // strict compare keeps the earliest of equal maxima
  assign upd     = start || (sample > best_val);
  assign res_val = upd ? sample  : best_val;
  assign res_idx = upd ? cur_idx : best_idx;
  assign last    = take && (cur_idx == IW'(WINDOW - 1));
  assign done    = last && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      best_val <= '0;
      best_idx <= '0;
    end else if (abort) begin
      busy     <= 1'b0;
      cnt      <= '0;
      best_val <= '0;
      best_idx <= '0;
    end else if (take) begin
      best_val <= res_val;
      best_idx <= res_idx;
      busy     <= !last;
      cnt      <= last ? '0 : cur_idx + 1'b1;
    end
  end

  // R2
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort) |=> (best_val >= $past(best_val)));

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < IW'(WINDOW)));
endmodule

// File: rtl/trig_peak_finder.sv
module trig_peak_finder
  import tpf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = ADC_W,
  parameter int unsigned DELAY    = DELAY_CYC,
  parameter int unsigned WINDOW   = WINDOW_CYC,
  localparam int unsigned IW      = $clog2(WINDOW)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                trig,
  input  logic                trig_rst,
  input  logic                buf_full,
  output logic [SAMPLE_W-1:0] peak_val,
  output logic [IW-1:0]       peak_idx,
  output logic                peak_valid
);
  logic [SAMPLE_W-1:0] dly_sample;
  logic                trk_done;
  logic [SAMPLE_W-1:0] trk_val;
  logic [IW-1:0]       trk_idx;

  tpf_delay_line #(.W(SAMPLE_W), .DEPTH(DELAY)) u_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sample_in),
    .tap  (dly_sample)
  );

  tpf_peak_tracker #(.W(SAMPLE_W), .WINDOW(WINDOW)) u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (trig_rst),
    .start_req(trig),
    .block    (buf_full),
    .sample   (dly_sample),
    .done     (trk_done),
    .res_val  (trk_val),
    .res_idx  (trk_idx)
  );

  logic publish;
  assign publish = trk_done && !buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_valid <= 1'b0;
      peak_val   <= '0;
      peak_idx   <= '0;
    end else if (trig_rst) begin
      peak_valid <= 1'b0;
      peak_val   <= '0;
      peak_idx   <= '0;
    end else begin
      peak_valid <= publish;
      if (publish) begin
        peak_val <= trk_val;
        peak_idx <= trk_idx;
      end
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_valid |=> !peak_valid);

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    peak_valid |-> (peak_idx < IW'(WINDOW)));

  // R7
  abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rst |=> (!peak_valid && peak_val == '0 && peak_idx == '0));

  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |=> !peak_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trk_done && !trig_rst) |=> ($stable(peak_val) && $stable(peak_idx)));
endmodule

// File: tb/trig_peak_finder_tb.sv
module trig_peak_finder_tb_top;
  localparam int CLK_PERIOD = 50;
  localparam int DLY = 64;
  localparam int WIN = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic       trig_rst = 1'b0;
  logic       buf_full = 1'b0;
  logic [9:0] sample_in;
  logic [9:0] peak_val;
  logic [5:0] peak_idx;
  logic       peak_valid;

  int         cyc = 0;
  int         vcount = 0;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;
  logic [9:0] stim [4096];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (peak_valid) vcount++;
  assign sample_in = stim[cyc & 4095];

  trig_peak_finder dut_i (
    .clk(clk), .rst_n(rst_n), .sample_in(sample_in), .trig(trig),
    .trig_rst(trig_rst), .buf_full(buf_full), .peak_val(peak_val),
    .peak_idx(peak_idx), .peak_valid(peak_valid)
  );

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic fire_at(int t);
    wait_to(t);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic model(int t, output int v, output int ix);
    v = -1; ix = 0;
    for (int j = 0; j < WIN; j++) begin
      int s = stim[(t - DLY + j) & 4095];
      if (s > v) begin v = s; ix = j; end
    end
  endtask

  task automatic expect_result(int t, string req);
    int v, ix;
    model(t, v, ix);
    wait_to(t + WIN - 1);
    check(peak_valid == 1'b0, {req, " early valid"}, peak_valid, 0);
    wait_to(t + WIN);
    check(peak_valid == 1'b1, {req, " valid"}, peak_valid, 1);
    check(peak_val == v, {req, " value"}, peak_val, v);
    check(peak_idx == ix, {req, " index"}, peak_idx, ix);
    @(negedge clk);
    check(peak_valid == 1'b0, {req, " R3 one-cycle"}, peak_valid, 0);
  endtask

  task automatic test_reset;
    check(peak_valid == 0, "R9 valid", peak_valid, 0);
    check(peak_val == 0, "R9 value", peak_val, 0);
    check(peak_idx == 0, "R9 index", peak_idx, 0);
  endtask

  task automatic test_basic;
    int t = cyc + 80;
    int s0 = t - DLY;
    for (int j = 0; j < WIN; j++) stim[(s0 + j) & 4095] = 10'(50 + j);
    stim[(s0 + 23) & 4095] = 10'd777;
    fire_at(t);
    expect_result(t, "R1 R2");
    check(peak_idx == 23, "R1 index", peak_idx, 23);
    repeat (10) @(negedge clk);
    check(peak_val == 777, "R10 hold", peak_val, 777);
  endtask

  task automatic test_tie;
    int t = cyc + 80;
    int s0 = t - DLY;
    for (int j = 0; j < WIN; j++) stim[(s0 + j) & 4095] = 10'd100;
    stim[(s0 - 1) & 4095]   = 10'd1023;
    stim[(s0 + WIN) & 4095] = 10'd1023;
    stim[(s0 + 10) & 4095]  = 10'd900;
    stim[(s0 + 30) & 4095]  = 10'd900;
    fire_at(t);
    expect_result(t, "R4 R5");
    check(peak_idx == 10, "R4 earliest", peak_idx, 10);
    check(peak_val == 900, "R5 outside", peak_val, 900);
  endtask

  task automatic test_edges;
    int t = cyc + 80;
    int s0 = t - DLY;
    for (int j = 0; j < WIN; j++) stim[(s0 + j) & 4095] = 10'd5;
    stim[(s0 + WIN - 1) & 4095] = 10'd1023;
    fire_at(t);
    expect_result(t, "R2 last");
    check(peak_idx == 49, "R2 idx49", peak_idx, 49);
    t = cyc + 80;
    s0 = t - DLY;
    for (int j = 0; j < WIN; j++) stim[(s0 + j) & 4095] = 10'(300 - j);
    fire_at(t);
    expect_result(t, "R2 first");
    check(peak_idx == 0, "R2 idx0", peak_idx, 0);
  endtask

  task automatic test_retrig;
    int t = cyc + 80;
    int c0;
    fire_at(t);
    c0 = vcount;
    fire_at(t + 20);
    expect_result(t, "R6 first");
    wait_to(t + 20 + WIN + 10);
    check(vcount - c0 == 1, "R6 single", vcount - c0, 1);
  endtask

  task automatic test_abort;
    int t = cyc + 80;
    int c0 = vcount;
    check(peak_val != 0, "R7 pre", peak_val, 1);
    fire_at(t);
    wait_to(t + 20);
    trig_rst = 1'b1;
    @(negedge clk);
    trig_rst = 1'b0;
    check(peak_val == 0 && peak_idx == 0, "R7 cleared", peak_val, 0);
    wait_to(t + WIN + 10);
    check(vcount == c0, "R7 aborted", vcount - c0, 0);
  endtask

  task automatic test_full;
    int t = cyc + 80;
    int c0 = vcount;
    int held;
    stim[(t - DLY + 7) & 4095] = 10'd1000;
    fire_at(t);
    expect_result(t, "R8 setup");
    held = peak_val;
    t = cyc + 80;
    wait_to(t);
    buf_full = 1'b1;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    buf_full = 1'b0;
    c0 = vcount;
    wait_to(t + WIN + 10);
    check(vcount == c0, "R8 trig refused", vcount - c0, 0);
    t = cyc + 80;
    stim[(t - DLY + 3) & 4095] = 10'd1;
    fire_at(t);
    c0 = vcount;
    wait_to(t + WIN - 3);
    buf_full = 1'b1;
    wait_to(t + WIN + 3);
    buf_full = 1'b0;
    wait_to(t + WIN + 10);
    check(vcount == c0, "R8 result dropped", vcount - c0, 0);
    check(peak_val == held, "R8 R10 unchanged", peak_val, held);
    t = cyc + 80;
    fire_at(t);
    expect_result(t, "R8 recovery");
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) stim[k] = 10'((k * 173 + 29) % 700);
    repeat (3) @(negedge clk);
    test_reset;
    rst_n = 1'b1;
    @(negedge clk);
    test_basic;
    test_tie;
    test_edges;
    test_retrig;
    test_abort;
    test_full;
    finish_run;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run;
  end
endmodule